// File: doc/BRIEF.md
# Transmit Flow-Control Update Generator

This block watches the read side of a transmit packet buffer and tells the sending side how far consumption has progressed. Every time the buffer hands a packet onward, the block pulses its consume input. The block keeps the number of the most recent packet taken out. From time to time it offers a 64-bit status word that carries a programmable stream identifier and that number. The sender uses these words to decide when it may push more data.

A report is raised by either of two triggers. The first is a timer that expires after a programmed number of clock cycles. The second is a packet counter that expires after a programmed number of consume pulses. Each trigger has its own enable flag. When either trigger fires, both counters start again from zero, so a single event never causes two reports in a row. A stalled output keeps at most one report waiting. That report always shows the newest values. Software sets up the block through a small write-only register port.

Top module: `txfc_update_gen`

## Requirements
- R1: After reset, `st_valid` is low, `st_data[63:32]` is 0 and `st_data[31:0]` is 32'hFFFF_FFFF, meaning that no packet has been consumed yet.
- R2: Register writes are decoded by `cfg_addr`. Offset 1 is clear-state, where the data is ignored. Offset 2 is the stream identifier. Offset 4 is the cycle trigger. Offset 5 is the packet trigger. The status word is {stream identifier in [63:32], last-consumed number in [31:0]}, and `st_data` always shows the current values, whether `st_valid` is high or low.
- R3: Each consume pulse advances the last-consumed number by one, modulo 2^32. The first packet consumed after reset or clear-state is numbered 0.
- R4: In a trigger register, bit 31 is the enable and bits [30:0] hold the count N. With the cycle trigger enabled and N at least 2, consecutive reports with `st_ready` high rise exactly N cycles apart.
- R5: With the packet trigger enabled and count N, the report is raised in the cycle after the consume pulse that completes N consumptions since the last restart. The report carries that packet's number.
- R6: A trigger whose enable bit is clear, or whose count is 0, never raises a report. Writing 0 to both trigger registers stops all reports.
- R7: A firing of either trigger restarts both counters. After a packet-triggered report, the next timer report comes a full N cycles later.
- R8: While `st_ready` is low, at most one report is held. Further firings merge into it, it carries the newest number, and exactly one handshake drains it.
- R9: A clear-state write drops any pending report, returns the number to 32'hFFFF_FFFF, and zeroes both trigger counters. The trigger configuration and the stream identifier are kept.
- R10: The stream identifier written at offset 2 appears in `st_data[63:32]` from the next cycle and does not change until it is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register offset |
| cfg_wdata | input | 32 | Register write data |
| consume | input | 1 | One pulse per packet taken from the buffer |
| st_valid | output | 1 | Status report pending |
| st_ready | input | 1 | Receiver accepts the status word |
| st_data | output | 64 | {stream identifier, last-consumed number} |

## Verification
The timer is tried alone. The gap between reports is measured, which shows whether the count is exact or off by one. The packet trigger is driven with bursts that end just short of the count and then reach it. This shows the firing edge and the number carried in the report. A mixed pattern starts the timer, then fires the packet trigger in the middle of its count. This separates a shared restart from counters that run independently. Stalled output combined with extra firings, clear-state in the middle of a count, and the disabled or zero-count settings cover merging, reset of the counters and the off cases.

// File: rtl/txfc_pkg.sv
package txfc_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned CNT_W  = WORD_W - 1;
    localparam int unsigned N_TRIG = 2;
    localparam int unsigned TRIG_CYC = 0;
    localparam int unsigned TRIG_PKT = 1;

    localparam int unsigned ADR_CLEAR = 1;
    localparam int unsigned ADR_SID   = 2;
    localparam int unsigned ADR_CYC   = 4;
    localparam int unsigned ADR_PKT   = 5;

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] limit;
    } trig_cfg_t;

    typedef struct packed {
        logic [WORD_W-1:0] sid;
        logic [WORD_W-1:0] seq;
    } status_word_t;

    function automatic trig_cfg_t to_trig_cfg(input logic [WORD_W-1:0] w);
        trig_cfg_t c;
        c.en    = w[WORD_W-1];
        c.limit = w[CNT_W-1:0];
        return c;
    endfunction
endpackage

// File: rtl/txfc_cfg_regs.sv
module txfc_cfg_regs
    import txfc_pkg::*;
#(
    parameter int unsigned CFG_AW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic              clr,
    output logic [WORD_W-1:0] sid,
    output trig_cfg_t         trig [N_TRIG]
);
    localparam logic [CFG_AW-1:0] A_CLR = CFG_AW'(ADR_CLEAR);
    localparam logic [CFG_AW-1:0] A_SID = CFG_AW'(ADR_SID);
    localparam logic [CFG_AW-1:0] A_CYC = CFG_AW'(ADR_CYC);
    localparam logic [CFG_AW-1:0] A_PKT = CFG_AW'(ADR_PKT);

    assign clr = we && (addr == A_CLR);

    always_ff @(posedge clk) begin
        if (rst) begin
            sid <= '0;
        end else if (we && addr == A_SID) begin
            sid <= wdata;
        end
    end

    for (genvar g = 0; g < N_TRIG; g++) begin : g_trig_reg
        localparam logic [CFG_AW-1:0] MY_ADR = (g == TRIG_CYC) ? A_CYC : A_PKT;
        always_ff @(posedge clk) begin
            if (rst) begin
                trig[g] <= '0;
            end else if (we && addr == MY_ADR) begin
                trig[g] <= to_trig_cfg(wdata);
            end
        end
    end
endmodule

// File: rtl/txfc_trigger.sv
module txfc_trigger
    import txfc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  trig_cfg_t cfg,
    input  logic      tick,
    input  logic      restart,
    output logic      fire
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + 1'b1;
    assign fire = cfg.en && (cfg.limit != '0) && tick && (cnt_inc >= {1'b0, cfg.limit});

    always_ff @(posedge clk) begin
        if (rst || clr || restart) begin
            cnt <= '0;
        end else if (cfg.en && tick) begin
            cnt <= cnt_inc[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/txfc_seq_track.sv
module txfc_seq_track
    import txfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              consume,
    output logic [WORD_W-1:0] last_seq
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            last_seq <= '1;
        end else if (consume) begin
            last_seq <= last_seq + 1'b1;
        end
    end
endmodule

// File: rtl/txfc_update_gen.sv
module txfc_update_gen
    import txfc_pkg::*;
#(
    parameter int unsigned CFG_AW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              consume,
    output logic              st_valid,
    input  logic              st_ready,
    output logic [63:0]       st_data
);
    logic              clr;
    logic [WORD_W-1:0] sid;
    logic [WORD_W-1:0] last_seq;
    trig_cfg_t         trig_cfg [N_TRIG];
    logic [N_TRIG-1:0] trig_fire;
    logic [N_TRIG-1:0] trig_tick;
    logic [N_TRIG-1:0] trig_en;
    logic              fire_any;
    logic              pending;
    status_word_t      word;

    txfc_cfg_regs #(.CFG_AW(CFG_AW)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .clr   (clr),
        .sid   (sid),
        .trig  (trig_cfg)
    );

    txfc_seq_track u_seq (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .consume  (consume),
        .last_seq (last_seq)
    );

    assign trig_tick[TRIG_CYC] = 1'b1;
    assign trig_tick[TRIG_PKT] = consume;
    assign fire_any = |trig_fire;

    for (genvar g = 0; g < N_TRIG; g++) begin : g_trig
        assign trig_en[g] = trig_cfg[g].en;
        txfc_trigger u_trig (
            .clk     (clk),
            .rst     (rst),
            .clr     (clr),
            .cfg     (trig_cfg[g]),
            .tick    (trig_tick[g]),
            .restart (fire_any),
            .fire    (trig_fire[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pending <= 1'b0;
        end else if (fire_any) begin
            pending <= 1'b1;
        end else if (st_ready) begin
            pending <= 1'b0;
        end
    end

    assign word.sid = sid;
    assign word.seq = last_seq;
    assign st_valid = pending;
    assign st_data  = word;
endmodule

// File: rtl/txfc_update_gen_chk.sv
module txfc_update_gen_chk
    import txfc_pkg::*;
#(
    parameter int unsigned CFG_AW = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic              consume,
    input logic              st_valid,
    input logic              st_ready,
    input logic [63:0]       st_data,
    input logic              fire_any,
    input logic [N_TRIG-1:0] trig_en
);
    logic clear_wr;
    logic sid_wr;
    assign clear_wr = cfg_we && (cfg_addr == CFG_AW'(ADR_CLEAR));
    assign sid_wr   = cfg_we && (cfg_addr == CFG_AW'(ADR_SID));

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        consume && !clear_wr |=> st_data[31:0] == $past(st_data[31:0]) + 32'd1); // R3
    AST_SID_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sid_wr |=> $stable(st_data[63:32])); // R10
    AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (rst)
        clear_wr |=> !st_valid && st_data[31:0] == 32'hFFFF_FFFF); // R9
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        st_valid && !st_ready && !clear_wr |=> st_valid); // R8
    AST_SINGLE_DRAIN: assert property (@(posedge clk) disable iff (rst)
        st_valid && st_ready && !fire_any && !clear_wr |=> !st_valid); // R8
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        trig_en == '0 |-> !fire_any); // R6
    AST_FIRE_RAISES: assert property (@(posedge clk) disable iff (rst)
        fire_any && !clear_wr |=> st_valid); // R7
endmodule

bind txfc_update_gen txfc_update_gen_chk #(.CFG_AW(CFG_AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .consume  (consume),
    .st_valid (st_valid),
    .st_ready (st_ready),
    .st_data  (st_data),
    .fire_any (fire_any),
    .trig_en  (trig_en)
);

// File: tb/txfc_update_gen_tb_top.sv
`timescale 1ns/1ps
module txfc_update_gen_tb_top;
    localparam int AW = 3;
    localparam logic [AW-1:0] A_CLR = 3'd1;
    localparam logic [AW-1:0] A_SID = 3'd2;
    localparam logic [AW-1:0] A_CYC = 3'd4;
    localparam logic [AW-1:0] A_PKT = 3'd5;
    localparam logic [31:0] EN = 32'h8000_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          consume = 1'b0;
    logic          st_ready = 1'b0;
    logic          st_valid;
    logic [63:0]   st_data;
    int            n_chk = 0;
    int            n_fail = 0;
    int            hs_cnt = 0;

    always #2.5 clk = ~clk;

    txfc_update_gen #(.CFG_AW(AW)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .consume(consume), .st_valid(st_valid),
        .st_ready(st_ready), .st_data(st_data)
    );

    always @(posedge clk) if (!rst && st_valid && st_ready) hs_cnt <= hs_cnt + 1;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic consume_n(input int n);
        for (int i = 0; i < n; i++) begin
            consume = 1'b1;
            @(negedge clk);
        end
        consume = 1'b0;
    endtask

    task automatic gap_to_valid(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!st_valid && n < 1000);
    endtask

    task automatic t_reset;  // R1
        @(negedge clk);
        check(!st_valid, "R1 valid", 64'(st_valid), 64'd0);
        check(st_data == 64'h0000_0000_FFFF_FFFF, "R1 data", st_data, 64'h0000_0000_FFFF_FFFF);
    endtask

    task automatic t_timer;  // R4 R10 R2
        int gap;
        cfg_write(A_SID, 32'hA5A5_0001);
        @(negedge clk);
        check(st_data[63:32] == 32'hA5A5_0001, "R10 sid", 64'(st_data[63:32]), 64'hA5A5_0001);
        cfg_write(A_CLR, 32'h0);
        st_ready = 1'b1;
        cfg_write(A_CYC, EN | 32'd10);
        gap_to_valid(gap);
        check(st_data == 64'hA5A5_0001_FFFF_FFFF, "R2 word", st_data, 64'hA5A5_0001_FFFF_FFFF);
        gap_to_valid(gap);
        check(gap == 10, "R4 period", 64'(gap), 64'd10);
        gap_to_valid(gap);
        check(gap == 10, "R4 period again", 64'(gap), 64'd10);
        cfg_write(A_CYC, 32'h0);
        cfg_write(A_CLR, 32'h0);
    endtask

    task automatic t_packets;  // R5 R3
        bit early = 1'b0;
        cfg_write(A_PKT, EN | 32'd4);
        for (int i = 0; i < 3; i++) begin
            consume = 1'b1;
            @(negedge clk);
            if (st_valid) early = 1'b1;
        end
        check(!early, "R5 no early report", 64'(early), 64'd0);
        consume_n(1);
        check(st_valid, "R5 report", 64'(st_valid), 64'd1);
        check(st_data[31:0] == 32'd3, "R3 number", 64'(st_data[31:0]), 64'd3);
        consume_n(4);
        check(st_valid && st_data[31:0] == 32'd7, "R5 second report", st_data, 64'hA5A5_0001_0000_0007);
        cfg_write(A_PKT, 32'h0);
        cfg_write(A_CLR, 32'h0);
    endtask

    task automatic t_disabled;  // R6
        int h0 = hs_cnt;
        bit seen = 1'b0;
        cfg_write(A_PKT, 32'd4);
        cfg_write(A_CYC, 32'd5);
        consume_n(10);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (st_valid) seen = 1'b1;
        end
        check(!seen && hs_cnt == h0, "R6 enable clear", 64'(hs_cnt - h0), 64'd0);
        cfg_write(A_PKT, EN);
        cfg_write(A_CYC, EN);
        consume_n(6);
        repeat (10) @(negedge clk);
        check(hs_cnt == h0, "R6 zero count", 64'(hs_cnt - h0), 64'd0);
        cfg_write(A_PKT, 32'h0);
        cfg_write(A_CYC, 32'h0);
        repeat (30) @(negedge clk);
        check(hs_cnt == h0, "R6 both zero", 64'(hs_cnt - h0), 64'd0);
        cfg_write(A_CLR, 32'h0);
    endtask

    task automatic t_restart;  // R7
        int gap;
        cfg_write(A_PKT, EN | 32'd3);
        cfg_write(A_CYC, EN | 32'd20);
        repeat (10) @(negedge clk);
        consume_n(3);
        check(st_valid && st_data[31:0] == 32'd2, "R7 packet report", st_data, 64'hA5A5_0001_0000_0002);
        gap_to_valid(gap);
        check(gap == 20, "R7 timer restarted", 64'(gap), 64'd20);
        cfg_write(A_PKT, 32'h0);
        cfg_write(A_CYC, 32'h0);
        cfg_write(A_CLR, 32'h0);
    endtask

    task automatic t_stall;  // R8
        int h0;
        st_ready = 1'b0;
        cfg_write(A_PKT, EN | 32'd2);
        consume_n(2);
        check(st_valid && st_data[31:0] == 32'd1, "R8 first", st_data, 64'hA5A5_0001_0000_0001);
        consume_n(2);
        check(st_valid && st_data[31:0] == 32'd3, "R8 newest", st_data, 64'hA5A5_0001_0000_0003);
        h0 = hs_cnt;
        st_ready = 1'b1;
        @(negedge clk);
        check(!st_valid, "R8 drained", 64'(st_valid), 64'd0);
        repeat (5) @(negedge clk);
        check(hs_cnt - h0 == 1, "R8 one handshake", 64'(hs_cnt - h0), 64'd1);
        cfg_write(A_PKT, 32'h0);
        cfg_write(A_CLR, 32'h0);
    endtask

    task automatic t_clear;  // R9
        bit early = 1'b0;
        st_ready = 1'b0;
        cfg_write(A_PKT, EN | 32'd3);
        consume_n(3);
        check(st_valid, "R9 pending before clear", 64'(st_valid), 64'd1);
        consume_n(2);
        cfg_write(A_CLR, 32'h0);
        check(!st_valid && st_data[31:0] == 32'hFFFF_FFFF, "R9 cleared", st_data, 64'hA5A5_0001_FFFF_FFFF);
        for (int i = 0; i < 2; i++) begin
            consume = 1'b1;
            @(negedge clk);
            if (st_valid) early = 1'b1;
        end
        check(!early, "R9 counter zeroed", 64'(early), 64'd0);
        consume_n(1);
        check(st_valid && st_data[31:0] == 32'd2, "R9 count from zero", st_data, 64'hA5A5_0001_0000_0002);
        st_ready = 1'b1;
        cfg_write(A_PKT, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_timer();
        t_packets();
        t_disabled();
        t_restart();
        t_stall();
        t_clear();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule